// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block converts pointer events into fixed five-byte serial mouse packets and holds them in a byte queue until a consumer drains it. Each event arrives as a single-cycle strobe with signed horizontal and vertical motion and a three-bit button state. The block formats the whole packet and stores all five bytes in the same clock edge. A packet is accepted only when the queue has room for all five bytes, so the consumer never sees part of a packet.

The consumer side is a received-data port. A byte-available flag is high whenever the queue holds data. The oldest byte is always presented on the data output, and a pop strobe removes it. Queue depth and motion input width are parameters; the packet length is fixed at five.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty and `rx_avail` is 0.
- R2: The first byte of a packet is a header with bit 7 set and bits 6..3 clear. Bits 2, 1 and 0 are the inverted left, middle and right button states, taken from `evt_btn[2]`, `evt_btn[1]` and `evt_btn[0]`. With no button pressed the header is 0x87.
- R3: The five bytes of a packet are queued in this order: header, horizontal byte, vertical byte, 0x00, 0x00.
- R4: The horizontal byte is `evt_dx` limited to the range -127..+127 and written in 8-bit two's complement, so it is never 0x80.
- R5: The vertical byte is `evt_dy` limited to -127..+127 and then negated, written in 8-bit two's complement.
- R6: An event is accepted only when at least 5 entries are free before that cycle's pop. Otherwise the whole event is discarded and no byte is stored. The queue never holds more than DEPTH bytes.
- R7: `rx_avail` is 1 exactly when the queue holds at least one byte, and `rx_data` shows the oldest queued byte.
- R8: `rx_pop` while `rx_avail` is 1 removes the oldest byte. `rx_pop` on an empty queue has no effect.
- R9: The read and write positions wrap at DEPTH, and bytes come out in the order they were stored across the wrap.
- R10: An accepted event and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle pointer event strobe |
| evt_dx | input | MOVE_W | Signed horizontal motion |
| evt_dy | input | MOVE_W | Signed vertical motion |
| evt_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| rx_pop | input | 1 | Remove the oldest byte |
| rx_avail | output | 1 | Queue holds at least one byte |
| rx_data | output | 8 | Oldest queued byte |

## Verification
The hardest state to reach from the ports is a queue one packet short of full, with the write position wrapped past the end of storage. The stimulus first drains a few packets so that the positions sit off zero. It then pushes 51 packets, which leaves 255 bytes queued and a single free slot, and checks that the next event is refused. After popping exactly four bytes, the free count is exactly five and an event must be accepted, filling the queue. A reference queue in the bench is compared with the outputs on every clock while the full queue drains across the wrap.

// File: rtl/mouse_pkt_pkg.sv
package mouse_pkt_pkg;
   localparam int PKT_LEN = 5;
   localparam int BYTE_W  = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef struct packed {
      logic left;
      logic middle;
      logic right;
   } btn_t;

   function automatic byte_t make_header(input btn_t b);
      return {5'b10000, ~b.left, ~b.middle, ~b.right};
   endfunction
endpackage

// File: rtl/mouse_pkt_fmt.sv
module mouse_pkt_fmt
   import mouse_pkt_pkg::*;
#(
   parameter int MOVE_W = 10
) (
   input  logic signed [MOVE_W-1:0] dx,
   input  logic signed [MOVE_W-1:0] dy,
   input  btn_t                     btn,
   output byte_t [PKT_LEN-1:0]      bytes
);
   logic signed [7:0] cx, cy;

   if (MOVE_W < 8 || MOVE_W > 32) begin : g_bad_width
      $error("mouse_pkt_fmt: MOVE_W must be 8..32");
   end

   if (MOVE_W == 8) begin : g_narrow
      always_comb begin
         cx = (dx == -8'sd128) ? -8'sd127 : dx;
         cy = (dy == -8'sd128) ? -8'sd127 : dy;
      end
   end else begin : g_wide
      localparam logic signed [MOVE_W-1:0] LIM_HI = MOVE_W'(127);
      localparam logic signed [MOVE_W-1:0] LIM_LO = -LIM_HI;
      always_comb begin
         if (dx > LIM_HI)      cx = 8'sd127;
         else if (dx < LIM_LO) cx = -8'sd127;
         else                  cx = $signed(dx[7:0]);
         if (dy > LIM_HI)      cy = 8'sd127;
         else if (dy < LIM_LO) cy = -8'sd127;
         else                  cy = $signed(dy[7:0]);
      end
   end

   always_comb begin
      bytes[0] = make_header(btn);
      bytes[1] = byte_t'(cx);
      bytes[2] = byte_t'(-cy);
   end

   for (genvar k = 3; k < PKT_LEN; k++) begin : g_trail
      assign bytes[k] = '0;
   end
endmodule

// File: rtl/mouse_pkt_fifo.sv
module mouse_pkt_fifo
   import mouse_pkt_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  byte_t [PKT_LEN-1:0]  pkt,
   input  logic                 pop,
   output logic                 avail,
   output byte_t                dout
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] ROOM_MAX = CW'(DEPTH - PKT_LEN);
   localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 * PKT_LEN) begin : g_bad_depth
      $error("mouse_pkt_fifo: DEPTH must be a power of two of at least two packets");
   end

   byte_t          mem [DEPTH];
   logic [AW-1:0]  wptr, rptr;
   logic [CW-1:0]  cnt;
   logic           accept, pop_ok;

   assign accept = push && (cnt <= ROOM_MAX);
   assign pop_ok = pop && (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (accept) wptr <= wptr + AW'(PKT_LEN);
         if (pop_ok) rptr <= rptr + AW'(1);
         cnt <= cnt + (accept ? CW'(PKT_LEN) : '0) - (pop_ok ? CW'(1) : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         for (int k = 0; k < PKT_LEN; k++) begin
            mem[wptr + AW'(k)] <= pkt[k];
         end
      end
   end

   assign avail = (cnt != '0);
   assign dout  = mem[rptr];

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);
   p_full_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt > ROOM_MAX && !pop) |=> $stable(cnt));
   p_push_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt <= ROOM_MAX && !pop) |=> cnt == $past(cnt) + CW'(PKT_LEN));
   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt == '0 && !push) |=> cnt == '0);
   p_pop_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && cnt != '0 && !push) |=> cnt == $past(cnt) - CW'(1));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
   import mouse_pkt_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int MOVE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [MOVE_W-1:0] evt_dx,
   input  logic [MOVE_W-1:0] evt_dy,
   input  logic [2:0]        evt_btn,
   input  logic              rx_pop,
   output logic              rx_avail,
   output logic [7:0]        rx_data
);
   byte_t [PKT_LEN-1:0] pkt;

   mouse_pkt_fmt #(.MOVE_W(MOVE_W)) i_fmt (
      .dx    ($signed(evt_dx)),
      .dy    ($signed(evt_dy)),
      .btn   (btn_t'(evt_btn)),
      .bytes (pkt)
   );

   mouse_pkt_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (evt_valid),
      .pkt   (pkt),
      .pop   (rx_pop),
      .avail (rx_avail),
      .dout  (rx_data)
   );

   p_dx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> pkt[1] != 8'h80);
   p_dy_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> pkt[2] != 8'h80);
endmodule

// File: tb/test_mouse_pkt_enc.sv
module test_mouse_pkt_enc;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 256;
   localparam int MOVE_W     = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt_valid = 1'b0;
   logic [MOVE_W-1:0] evt_dx = '0;
   logic [MOVE_W-1:0] evt_dy = '0;
   logic [2:0]        evt_btn = '0;
   logic              rx_pop = 1'b0;
   logic              rx_avail;
   logic [7:0]        rx_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 0;
   int mq[$];

   mouse_pkt_enc #(.DEPTH(DEPTH), .MOVE_W(MOVE_W)) i_mouse_pkt_enc (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
      .evt_dy(evt_dy), .evt_btn(evt_btn), .rx_pop(rx_pop),
      .rx_avail(rx_avail), .rx_data(rx_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int lim(input int v);
      if (v > 127)  return 127;
      if (v < -127) return -127;
      return v;
   endfunction

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock: drive, update the reference, compare after the edge (R7, R10)
   task automatic cyc(input bit v, input int dx, input int dy, input int b, input bit p);
      int pre, h;
      @(negedge clk);
      evt_valid = v; evt_dx = MOVE_W'(dx); evt_dy = MOVE_W'(dy);
      evt_btn = 3'(b); rx_pop = p;
      pre = mq.size();
      if (p && pre > 0) void'(mq.pop_front());
      if (v && pre <= DEPTH - 5) begin
         h = 'h87;
         if (b & 4) h = h & ~4;
         if (b & 2) h = h & ~2;
         if (b & 1) h = h & ~1;
         mq.push_back(h);
         mq.push_back(lim(dx) & 255);
         mq.push_back((-lim(dy)) & 255);
         mq.push_back(0);
         mq.push_back(0);
      end
      @(posedge clk);
      #1;
      evt_valid = 0; rx_pop = 0;
      check(int'(rx_avail), int'(mq.size() != 0), "R7 avail vs model");
      if (mq.size() != 0) check(int'(rx_data), mq[0], "R7 data vs model");
   endtask

   task automatic expect_pop(input int exp, input string tag);
      check(int'(rx_avail), 1, tag);
      check(int'(rx_data), exp, tag);
      cyc(0, 0, 0, 0, 1);
   endtask

   task automatic drain(output int n);
      n = 0;
      while (rx_avail) begin
         cyc(0, 0, 0, 0, 1);
         n++;
      end
   endtask

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1;
      check(int'(rx_avail), 0, "R1 reset avail");
      @(negedge clk); rst_n = 1;
      cyc(0, 0, 0, 0, 0);
      check(int'(rx_avail), 0, "R1 idle after reset");

      // R2 R3 R5: no buttons, small motion
      cyc(1, 5, 10, 0, 0);
      expect_pop('h87, "R2 header none");
      expect_pop('h05, "R3 dx byte");
      expect_pop('hF6, "R5 dy negated");
      expect_pop('h00, "R3 trail 1");
      expect_pop('h00, "R3 trail 2");
      // R8: pop on empty
      cyc(0, 0, 0, 0, 1);
      check(int'(rx_avail), 0, "R8 pop empty");

      // R4 R5 clamps and button bits, two packets queued back to back
      cyc(1, 300, -200, 4, 0);
      cyc(1, -300, 127, 2, 0);
      expect_pop('h83, "R2 left");
      expect_pop('h7F, "R4 dx high clamp");
      expect_pop('h7F, "R5 dy low clamp");
      expect_pop('h00, "R3 trail");
      expect_pop('h00, "R3 trail");
      expect_pop('h85, "R2 middle");
      expect_pop('h81, "R4 dx low clamp");
      expect_pop('h81, "R5 dy max");
      drain(n);
      cyc(1, -128, 0, 1, 0);
      expect_pop('h86, "R2 right");
      expect_pop('h81, "R4 dx -128");
      expect_pop('h00, "R5 dy zero");
      drain(n);
      cyc(1, -1, 1, 7, 0);
      expect_pop('h80, "R2 all buttons");
      expect_pop('hFF, "R4 dx -1");
      expect_pop('hFF, "R5 dy 1");

      // R10: event and pop together
      cyc(1, 2, -3, 0, 1);
      check(mq.size(), 6, "R10 model size");
      drain(n);
      check(n, 6, "R10 push and pop both applied");

      // R6 R9: fill to one slot short, reject, then exact fit
      cyc(1, 1, 1, 0, 0);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 1);
      drain(n);
      for (int i = 0; i < 51; i++) cyc(1, i, -i, i % 8, 0);
      cyc(1, 9, 9, 0, 0);
      check(mq.size(), 255, "R6 model after refused event");
      repeat (4) cyc(0, 0, 0, 0, 1);
      cyc(1, 100, 100, 0, 0);
      cyc(1, 50, 50, 0, 0);
      drain(n);
      check(n, 256, "R6 exact fit then full reject");
      cyc(1, 33, -33, 3, 0);
      expect_pop('h84, "R9 header after wrap");
      expect_pop('h21, "R9 dx after wrap");
      expect_pop('h21, "R9 dy after wrap");
      drain(n);
      check(n, 2, "R9 tail after wrap");

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end
endmodule